// File: doc/BRIEF.md
# Multi-thread gate schedule engine

The engine runs a time-aware gate schedule for the egress queues of a switch. One linear table holds every timeslot entry for every port. Up to a parameterised number of execution threads each walk their own contiguous slice of that table, over and over. A thread starts once the time counter reaches a shared start time plus the thread's own offset. Within its slice, a thread holds each entry for that entry's duration. Durations are counted in delta ticks, where one delta is nominally 200 ns. While an entry is current, its mask of closed traffic-class gates is applied to every port named in the entry's destination bitmap.

Configuration goes into the table, the per-thread entry points and the per-thread end indices while the engine is stopped. Raising `run` arms the threads. Every thread whose index does not exceed the configured active count minus one is armed. When several threads drive the same port, their closed masks are merged. Dropping `run` halts every thread and opens all gates.

Top module: `gcl_engine`

## Requirements
- R1: After reset every gate is open (`gate_closed` is all zero) and `wr_err` is 0.
- R2: While `run` is 0, every thread is idle, and from the next clock on all gates are open.
- R3: Thread t starts on the first clock edge at which `run` is 1 and `cur_time` >= `start_time` + offset of thread t. Before that edge the thread closes no gate. After the edge it shows the entry at its entry-point address.
- R4: A thread whose index is greater than `active_m1` never starts. `active_m1` holds the number of active threads minus one.
- R5: A running thread keeps an entry current for exactly that entry's delta count of `delta_tick` pulses. It then moves to the next address. A delta count of zero is treated as one pulse.
- R6: After the entry at its end index, a thread returns to its entry-point address, so its slice repeats with a period equal to the sum of the slice's durations.
- R7: The current entry of a running thread closes, on each port whose bit is set in the entry's destination bitmap, the traffic classes set in its closed mask. This happens only when the entry's reserve enable is 1. With reserve enable 0, the entry closes nothing.
- R8: When several running threads close gates on the same port, the port's closed mask is the bitwise OR of their masks.
- R9: Writes to the table, to entry points and to end indices take effect only while `run` is 0. Any such write attempted while `run` is 1 is dropped and sets `wr_err`, which then stays 1 until reset.
- R10: `gate_closed` bit p*NUM_TC+c is 1 when traffic class c of port p is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Engine enable; 0 stops all threads |
| delta_tick | input | 1 | One-cycle strobe per elapsed delta |
| active_m1 | input | $clog2(NUM_THREADS) | Number of active threads minus one |
| start_time | input | TIME_W | Shared schedule start time, in deltas |
| cur_time | input | TIME_W | Current time, in deltas |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | $clog2(DEPTH) | Table entry address |
| tbl_delta | input | DW | Entry duration in deltas |
| tbl_ports | input | NUM_PORTS | Entry destination-port bitmap |
| tbl_resv_en | input | 1 | Entry reserve enable |
| tbl_closed | input | NUM_TC | Entry closed-gate mask |
| ep_we | input | 1 | Entry-point write strobe |
| ep_thread | input | $clog2(NUM_THREADS) | Thread index the entry point belongs to |
| ep_offset | input | DW | Start offset of that thread, in deltas |
| ep_addr | input | $clog2(DEPTH) | Table address of the thread's first entry |
| end_we | input | 1 | End-index write strobe |
| end_thread | input | $clog2(NUM_THREADS) | Thread whose end index is written |
| end_addr | input | $clog2(DEPTH) | Table address of the thread's last entry |
| gate_closed | output | NUM_PORTS*NUM_TC | Closed-gate masks, one NUM_TC field per port |
| wr_err | output | 1 | Sticky flag for a write attempted while running |

## Verification
The bench builds the engine with three ports, four threads, an eight-entry table, 8-bit durations and a 16-bit time counter. At that size a single sweep can step every delta across more than two full periods of three overlapping threads. Every port is checked at every delta against expected masks that the bench computes from the start times, the durations taken modulo the slice period, and the reserve enables. The sweep includes a zero-length entry, an entry with reserve enable 0 and a port shared by two threads. A fourth, configured but unarmed thread points at an entry that closes all gates, which brings R4 within reach at the ports. A later run with a single active thread, following a dropped write, shows that the write was discarded.

// File: rtl/gcl_pkg.sv
package gcl_pkg;

  // Address after `cur` inside the slice [first, last]; wraps back at the end.
  function automatic int unsigned gcl_next_slot(int unsigned cur,
                                                int unsigned first,
                                                int unsigned last);
    return (cur >= last) ? first : cur + 1;
  endfunction

  // A thread may start once now reaches base + offset.
  function automatic logic gcl_due(logic [63:0] now, logic [63:0] base,
                                   logic [63:0] ofs);
    return now >= (base + ofs);
  endfunction

endpackage

// File: rtl/gcl_table.sv
module gcl_table #(
  parameter int NUM_PORTS   = 5,
  parameter int NUM_TC      = 8,
  parameter int NUM_THREADS = 8,
  parameter int DEPTH       = 64,
  parameter int DW          = 19,
  localparam int AW = $clog2(DEPTH),
  localparam int TNW = $clog2(NUM_THREADS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic [DW-1:0]        tbl_delta,
  input  logic [NUM_PORTS-1:0] tbl_ports,
  input  logic                 tbl_resv_en,
  input  logic [NUM_TC-1:0]    tbl_closed,
  input  logic                 ep_we,
  input  logic [TNW-1:0]       ep_thread,
  input  logic [DW-1:0]        ep_offset,
  input  logic [AW-1:0]        ep_addr,
  input  logic                 end_we,
  input  logic [TNW-1:0]       end_thread,
  input  logic [AW-1:0]        end_addr,
  output logic [DW-1:0]        sl_delta  [DEPTH],
  output logic [NUM_PORTS-1:0] sl_ports  [DEPTH],
  output logic                 sl_resv   [DEPTH],
  output logic [NUM_TC-1:0]    sl_closed [DEPTH],
  output logic [DW-1:0]        th_offset [NUM_THREADS],
  output logic [AW-1:0]        th_first  [NUM_THREADS],
  output logic [AW-1:0]        th_last   [NUM_THREADS],
  output logic                 wr_err
);

  logic any_we, wr_ok, wr_blocked;
  assign any_we     = tbl_we | ep_we | end_we;
  assign wr_ok      = !run;
  assign wr_blocked = run && any_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        sl_delta[i]  <= '0;
        sl_ports[i]  <= '0;
        sl_resv[i]   <= 1'b0;
        sl_closed[i] <= '0;
      end
      for (int t = 0; t < NUM_THREADS; t++) begin
        th_offset[t] <= '0;
        th_first[t]  <= '0;
        th_last[t]   <= '0;
      end
      wr_err <= 1'b0;
    end else begin
      if (wr_ok && tbl_we) begin
        sl_delta[tbl_addr]  <= tbl_delta;
        sl_ports[tbl_addr]  <= tbl_ports;
        sl_resv[tbl_addr]   <= tbl_resv_en;
        sl_closed[tbl_addr] <= tbl_closed;
      end
      if (wr_ok && ep_we) begin
        th_offset[ep_thread] <= ep_offset;
        th_first[ep_thread]  <= ep_addr;
      end
      if (wr_ok && end_we)
        th_last[end_thread] <= end_addr;
      if (wr_blocked)
        wr_err <= 1'b1;
    end
  end

  AST_WR_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> wr_err); // R9
  AST_WR_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R9

endmodule

// File: rtl/gcl_thread.sv
module gcl_thread
  import gcl_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DW     = 19,
  parameter int TIME_W = 48,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              armed,
  input  logic              delta_tick,
  input  logic [TIME_W-1:0] cur_time,
  input  logic [TIME_W-1:0] start_time,
  input  logic [DW-1:0]     ofs,
  input  logic [AW-1:0]     first_addr,
  input  logic [AW-1:0]     last_addr,
  input  logic [DW-1:0]     slot_delta [DEPTH],
  output logic              active,
  output logic [AW-1:0]     ptr
);

  logic          active_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] remain_q;

  // Named events for the assertions
  logic          due, start_evt, step_evt, adv_evt, wrap_evt;
  logic [AW-1:0] nxt_ptr;

  assign due       = gcl_due(64'(cur_time), 64'(start_time), 64'(ofs));
  assign start_evt = run && !active_q && armed && due;
  assign step_evt  = run && active_q && delta_tick;
  assign adv_evt   = step_evt && (remain_q <= DW'(1));
  assign wrap_evt  = adv_evt && (ptr_q >= last_addr);
  assign nxt_ptr   = AW'(gcl_next_slot(32'(ptr_q), 32'(first_addr), 32'(last_addr)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      remain_q <= '0;
    end else if (!run) begin
      active_q <= 1'b0;
    end else if (start_evt) begin
      active_q <= 1'b1;
      ptr_q    <= first_addr;
      remain_q <= slot_delta[first_addr];
    end else if (adv_evt) begin
      ptr_q    <= nxt_ptr;
      remain_q <= slot_delta[nxt_ptr];
    end else if (step_evt) begin
      remain_q <= remain_q - DW'(1);
    end
  end

  assign active = active_q;
  assign ptr    = ptr_q;

  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !active_q); // R2
  AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !(run && armed && due)) |=> !active_q); // R3
  AST_START_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (active_q && ptr_q == $past(first_addr))); // R3
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ptr_q == $past(first_addr))); // R6
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && run && !adv_evt) |=> $stable(ptr_q)); // R5

endmodule

// File: rtl/gcl_engine.sv
module gcl_engine #(
  parameter int NUM_PORTS   = 5,
  parameter int NUM_TC      = 8,
  parameter int NUM_THREADS = 8,
  parameter int DEPTH       = 64,
  parameter int DW          = 19,
  parameter int TIME_W      = 48,
  localparam int AW  = $clog2(DEPTH),
  localparam int TNW = $clog2(NUM_THREADS),
  localparam int GW  = NUM_PORTS * NUM_TC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 delta_tick,
  input  logic [TNW-1:0]       active_m1,
  input  logic [TIME_W-1:0]    start_time,
  input  logic [TIME_W-1:0]    cur_time,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic [DW-1:0]        tbl_delta,
  input  logic [NUM_PORTS-1:0] tbl_ports,
  input  logic                 tbl_resv_en,
  input  logic [NUM_TC-1:0]    tbl_closed,
  input  logic                 ep_we,
  input  logic [TNW-1:0]       ep_thread,
  input  logic [DW-1:0]        ep_offset,
  input  logic [AW-1:0]        ep_addr,
  input  logic                 end_we,
  input  logic [TNW-1:0]       end_thread,
  input  logic [AW-1:0]        end_addr,
  output logic [GW-1:0]        gate_closed,
  output logic                 wr_err
);

  logic [DW-1:0]        sl_delta  [DEPTH];
  logic [NUM_PORTS-1:0] sl_ports  [DEPTH];
  logic                 sl_resv   [DEPTH];
  logic [NUM_TC-1:0]    sl_closed [DEPTH];
  logic [DW-1:0]        th_offset [NUM_THREADS];
  logic [AW-1:0]        th_first  [NUM_THREADS];
  logic [AW-1:0]        th_last   [NUM_THREADS];

  logic [NUM_THREADS-1:0] thr_active;
  logic [NUM_THREADS-1:0] thr_armed;
  logic [AW-1:0]          thr_ptr [NUM_THREADS];

  gcl_table #(
    .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC), .NUM_THREADS(NUM_THREADS),
    .DEPTH(DEPTH), .DW(DW)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .run(run),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_delta(tbl_delta),
    .tbl_ports(tbl_ports), .tbl_resv_en(tbl_resv_en), .tbl_closed(tbl_closed),
    .ep_we(ep_we), .ep_thread(ep_thread), .ep_offset(ep_offset), .ep_addr(ep_addr),
    .end_we(end_we), .end_thread(end_thread), .end_addr(end_addr),
    .sl_delta(sl_delta), .sl_ports(sl_ports), .sl_resv(sl_resv),
    .sl_closed(sl_closed), .th_offset(th_offset), .th_first(th_first),
    .th_last(th_last), .wr_err(wr_err)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign thr_armed[t] = (32'(t) <= 32'(active_m1));

    gcl_thread #(.DEPTH(DEPTH), .DW(DW), .TIME_W(TIME_W)) u_thr (
      .clk(clk), .rst_n(rst_n), .run(run), .armed(thr_armed[t]),
      .delta_tick(delta_tick), .cur_time(cur_time), .start_time(start_time),
      .ofs(th_offset[t]), .first_addr(th_first[t]), .last_addr(th_last[t]),
      .slot_delta(sl_delta), .active(thr_active[t]), .ptr(thr_ptr[t])
    );

    AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!thr_armed[t] && !thr_active[t]) |=> !thr_active[t]); // R4
  end

  // Merge: each running thread contributes its current entry's mask to the
  // ports in that entry's bitmap; contributions to one port are OR-ed.
  logic [GW-1:0] gate_c;
  always_comb begin
    gate_c = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (thr_active[t] && sl_resv[thr_ptr[t]] && sl_ports[thr_ptr[t]][p])
          gate_c[p*NUM_TC +: NUM_TC] = gate_c[p*NUM_TC +: NUM_TC] | sl_closed[thr_ptr[t]];
      end
    end
  end
  assign gate_closed = gate_c;

  AST_GATES_OPEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (gate_closed == '0)); // R2
  AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_active == '0) |-> (gate_closed == '0)); // R7

endmodule

// File: tb/gcl_engine_bench.sv
module gcl_engine_bench;
  localparam int NP = 3, NTC = 8, NT = 4, DEP = 8, DW = 8, TW = 16;
  localparam int AW = 3, TNW = 2;

  logic clk = 0, rst_n = 0, run = 0, delta_tick = 0;
  logic [TNW-1:0] active_m1 = '0;
  logic [TW-1:0] start_time = '0, cur_time = '0;
  logic tbl_we = 0, tbl_resv_en = 0, ep_we = 0, end_we = 0;
  logic [AW-1:0] tbl_addr = '0, ep_addr = '0, end_addr = '0;
  logic [DW-1:0] tbl_delta = '0, ep_offset = '0;
  logic [NP-1:0] tbl_ports = '0;
  logic [NTC-1:0] tbl_closed = '0;
  logic [TNW-1:0] ep_thread = '0, end_thread = '0;
  logic [NP*NTC-1:0] gate_closed;
  logic wr_err;

  always #4 clk = ~clk;

  gcl_engine #(.NUM_PORTS(NP), .NUM_TC(NTC), .NUM_THREADS(NT), .DEPTH(DEP),
               .DW(DW), .TIME_W(TW)) u_gcl_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .delta_tick(delta_tick),
    .active_m1(active_m1), .start_time(start_time), .cur_time(cur_time),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_delta(tbl_delta),
    .tbl_ports(tbl_ports), .tbl_resv_en(tbl_resv_en), .tbl_closed(tbl_closed),
    .ep_we(ep_we), .ep_thread(ep_thread), .ep_offset(ep_offset), .ep_addr(ep_addr),
    .end_we(end_we), .end_thread(end_thread), .end_addr(end_addr),
    .gate_closed(gate_closed), .wr_err(wr_err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench copy of the configuration it wrote
  int m_delta[DEP], m_ports[DEP], m_en[DEP], m_closed[DEP];
  int m_ofs[NT], m_first[NT], m_last[NT];
  int m_act;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int dur(int d);
    return (d == 0) ? 1 : d;
  endfunction

  // Expected closed mask of port p at time `now`, derived from R3/R5/R6/R7/R8
  function automatic int exp_gate(int p, int now);
    int res = 0;
    for (int t = 0; t <= m_act; t++) begin
      int ts = int'(start_time) + m_ofs[t];
      if (now >= ts) begin
        int period = 0, el, e;
        for (int a = m_first[t]; a <= m_last[t]; a++) period += dur(m_delta[a]);
        el = (now - ts) % period;
        e = m_first[t];
        while (el >= dur(m_delta[e])) begin
          el -= dur(m_delta[e]);
          e++;
        end
        if (m_en[e] != 0 && ((m_ports[e] >> p) & 1) != 0) res |= m_closed[e];
      end
    end
    return res;
  endfunction

  task automatic wr_tbl(int a, int d, int pm, int en, int c);
    @(negedge clk);
    tbl_we = 1; tbl_addr = AW'(a); tbl_delta = DW'(d); tbl_ports = NP'(pm);
    tbl_resv_en = en[0]; tbl_closed = NTC'(c);
    if (!run) begin
      m_delta[a] = d; m_ports[a] = pm; m_en[a] = en; m_closed[a] = c;
    end
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic wr_thr(int t, int ofs, int first, int last);
    @(negedge clk);
    ep_we = 1; ep_thread = TNW'(t); ep_offset = DW'(ofs); ep_addr = AW'(first);
    end_we = 1; end_thread = TNW'(t); end_addr = AW'(last);
    m_ofs[t] = ofs; m_first[t] = first; m_last[t] = last;
    @(negedge clk); ep_we = 0; end_we = 0;
  endtask

  task automatic step_and_check(string tag);
    @(negedge clk); delta_tick = 1;
    @(negedge clk); delta_tick = 0; cur_time = cur_time + 1'b1;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      int e = exp_gate(p, int'(cur_time));
      int a = int'(gate_closed[p*NTC +: NTC]);
      chk(a == e, tag, a, e);
    end
  endtask

  task automatic restart(int act);
    @(negedge clk); run = 0;
    @(negedge clk); cur_time = '0; active_m1 = TNW'(act); m_act = act;
    @(negedge clk); run = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(gate_closed == '0, "R1 gates open after reset", int'(gate_closed), 0);
    chk(wr_err == 0, "R1 wr_err clear after reset", int'(wr_err), 0);

    start_time = 16'd5;
    // Thread 0: slice 0..2, includes a zero-length entry (R5)
    wr_tbl(0, 2, 3'b001, 1, 8'h0F);
    wr_tbl(1, 3, 3'b001, 1, 8'hF0);
    wr_tbl(2, 0, 3'b001, 1, 8'h81);
    // Thread 1: slice 3..4, second entry has reserve enable 0 (R7)
    wr_tbl(3, 2, 3'b010, 1, 8'h03);
    wr_tbl(4, 1, 3'b010, 0, 8'hFF);
    // Thread 2: slice 5..6, shares port 1 with thread 1 (R8)
    wr_tbl(5, 3, 3'b110, 1, 8'h30);
    wr_tbl(6, 2, 3'b100, 1, 8'h0C);
    // Entry for the unarmed thread 3: would close everything on port 0 (R4)
    wr_tbl(7, 1, 3'b001, 1, 8'hFF);
    wr_thr(0, 1, 0, 2);
    wr_thr(1, 3, 3, 4);
    wr_thr(2, 4, 5, 6);
    wr_thr(3, 1, 7, 6);
    chk(wr_err == 0, "R9 stopped writes raise no error", int'(wr_err), 0);

    // Phase A: three active threads, fourth unarmed
    restart(2);
    for (int s = 0; s < 40; s++) begin
      step_and_check("R3 R5 R6 R7 R8 R10 R4 sweep");
      if (s == 20) begin
        wr_tbl(0, 2, 3'b111, 1, 8'h55);   // attempted while running
        @(negedge clk);
        chk(wr_err == 1, "R9 write while running sets wr_err", int'(wr_err), 1);
      end
    end

    // Stop: gates open (R2), error stays set (R9)
    @(negedge clk); run = 0;
    repeat (2) @(negedge clk);
    chk(gate_closed == '0, "R2 gates open when stopped", int'(gate_closed), 0);
    repeat (6) @(negedge clk); delta_tick = 1; @(negedge clk); delta_tick = 0;
    @(negedge clk);
    chk(gate_closed == '0, "R2 ticks while stopped keep gates open", int'(gate_closed), 0);
    chk(wr_err == 1, "R9 wr_err sticky", int'(wr_err), 1);

    // Phase B: only thread 0 active; entry 0 must still hold the original values (R9)
    restart(0);
    chk(gate_closed == '0, "R3 closed nothing before start", int'(gate_closed), 0);
    for (int s = 0; s < 16; s++) step_and_check("R9 R4 single thread sweep");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule